// File: doc/BRIEF.md
# Transmit Clock Activity Mode Detector

This block sits ahead of a line transmitter and chooses how the transmitter behaves by watching two clocks. One is the transmit clock, which carries the data rate. The other is the master clock. A faster free-running reference clock samples both of them. If the transmit clock is running, the block captures the positive and negative rail data on each of its falling edges and passes them on.

When the transmit clock stops, the block uses the level it stopped at and the state of the master clock to pick a mode:
- Stuck low: it disables the line driver.
- Stuck high while the master clock runs: it sends an all-ones stream paced by the master clock.
- Stuck high while the master clock is also stopped: it asserts a pulse-shaping disable.

No register selects the mode. The mode comes only from clock activity.

Top module: `txclk_activity_mode`

## Requirements
- R1: Out of reset, `mode_oh` is 4'b0010 (driver off), `drv_en` is 0, `shaper_off` is 0 and `ones_out` is 0.
- R2: While the transmit clock toggles, `mode_oh` is 4'b0001 (normal) and `drv_en` is 1, whether the master clock toggles, sits low or sits high.
- R3: On every synchronised falling edge of the transmit clock, `pos_out` and `neg_out` take the rail input values that were present at that edge, and they hold those values until the next falling edge.
- R4: When the transmit clock is held low for a full idle window, `mode_oh` becomes 4'b0010 and `drv_en` is 0, for any master clock activity.
- R5: When the transmit clock is held high and the master clock toggles, `mode_oh` becomes 4'b0100 (all ones) only after more than HIGH_LIMIT master clock rising edges have been seen while the transmit clock is high. Until then the previous mode is kept.
- R6: When the transmit clock is held high and the master clock is stuck at either level for a full idle window, `mode_oh` becomes 4'b1000, `shaper_off` is 1 and `drv_en` stays 1.
- R7: In the all-ones mode, `ones_out` gives one single-cycle pulse for each master clock rising edge, which is one per master clock period. In every other mode it stays 0.
- R8: After any transmit clock edge is detected, `mode_oh` is normal two reference cycles later and the high-time count is cleared.
- R9: `mode_oh` always has exactly one bit set. Bit 0 is normal, bit 1 is driver off, bit 2 is all ones and bit 3 is shaper off.
- R10: A clock is treated as stopped after STUCK_WIN reference cycles with no edge on its synchronised copy. Its stopped level is the last synchronised value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low reset |
| tclk_in | input | 1 | Transmit clock, asynchronous |
| mclk_in | input | 1 | Master clock, asynchronous |
| pos_in | input | 1 | Positive rail data |
| neg_in | input | 1 | Negative rail data |
| mode_oh | output | 4 | One-hot mode: bit 0 normal, bit 1 driver off, bit 2 all ones, bit 3 shaper off |
| drv_en | output | 1 | Line driver enable |
| shaper_off | output | 1 | Pulse-shaping disable |
| pos_out | output | 1 | Captured positive rail |
| neg_out | output | 1 | Captured negative rail |
| ones_out | output | 1 | All-ones bit strobe, one per master clock period |

## Verification
The assertions check several rules on every cycle:
- the mode stays one-hot;
- a detected transmit clock edge returns the block to normal two cycles later and clears the high-time count;
- the block moves to driver-off or shaper-off the cycle after the matching stopped-clock condition;
- all-ones mode is never entered before the high-time count passes its limit;
- the ones strobe never lasts two cycles.

Only the bench scenarios can show how the mode settles for each of the nine combinations of clock behaviour. The same holds for the exact number of ones pulses in a span of master clock periods, the point at which a long high level tips the block into all-ones mode, and the rail values captured on real falling edges.

// File: rtl/txclk_activity_mode.sv
module txclk_activity_mode #(
  parameter int STUCK_WIN  = 64,
  parameter int HIGH_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tclk_in,
  input  logic       mclk_in,
  input  logic       pos_in,
  input  logic       neg_in,
  output logic [3:0] mode_oh,
  output logic       drv_en,
  output logic       shaper_off,
  output logic       pos_out,
  output logic       neg_out,
  output logic       ones_out
);

  localparam int IW = $clog2(STUCK_WIN + 1);
  localparam int HW = $clog2(HIGH_LIMIT + 2);
  localparam logic [3:0] M_NORMAL = 4'b0001;
  localparam logic [3:0] M_OFF    = 4'b0010;
  localparam logic [3:0] M_ONES   = 4'b0100;
  localparam logic [3:0] M_NOSHP  = 4'b1000;

  logic [2:0] t_sy, m_sy;
  logic [1:0] r_s1, r_s2;
  logic [IW-1:0] t_idle, m_idle;
  logic [HW-1:0] hi_cnt;
  logic [3:0] mode_q, mode_nx;
  logic pos_q, neg_q, ones_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      t_sy <= '0;
      m_sy <= '0;
      r_s1 <= '0;
      r_s2 <= '0;
    end else begin
      t_sy <= {t_sy[1:0], tclk_in};
      m_sy <= {m_sy[1:0], mclk_in};
      r_s1 <= {neg_in, pos_in};
      r_s2 <= r_s1;
    end

  wire t_edge  = t_sy[1] ^ t_sy[2];
  wire t_fall  = t_sy[2] & ~t_sy[1];
  wire m_edge  = m_sy[1] ^ m_sy[2];
  wire m_rise  = m_sy[1] & ~m_sy[2];
  wire t_stuck = (t_idle == IW'(STUCK_WIN));
  wire m_stuck = (m_idle == IW'(STUCK_WIN));
  wire t_lvl   = t_sy[2];
  wire hi_over = (hi_cnt > HW'(HIGH_LIMIT));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       t_idle <= IW'(STUCK_WIN);
    else if (t_edge)  t_idle <= '0;
    else if (!t_stuck) t_idle <= t_idle + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       m_idle <= IW'(STUCK_WIN);
    else if (m_edge)  m_idle <= '0;
    else if (!m_stuck) m_idle <= m_idle + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             hi_cnt <= '0;
    else if (t_edge)                        hi_cnt <= '0;
    else if (t_sy[1] && m_rise && !hi_over) hi_cnt <= hi_cnt + 1'b1;

  always_comb begin
    mode_nx = mode_q;
    if (!t_stuck)      mode_nx = M_NORMAL;
    else if (!t_lvl)   mode_nx = M_OFF;
    else if (m_stuck)  mode_nx = M_NOSHP;
    else if (hi_over)  mode_nx = M_ONES;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= M_OFF;
      pos_q  <= 1'b0;
      neg_q  <= 1'b0;
      ones_q <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      ones_q <= (mode_q == M_ONES) && m_rise;
      if (t_fall) begin
        pos_q <= r_s2[0];
        neg_q <= r_s2[1];
      end
    end

  assign mode_oh    = mode_q;
  assign drv_en     = (mode_q != M_OFF);
  assign shaper_off = (mode_q == M_NOSHP);
  assign pos_out    = pos_q;
  assign neg_out    = neg_q;
  assign ones_out   = ones_q;

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_q) == 1);

  p_edge_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    t_edge |=> ##1 (mode_q == M_NORMAL));

  p_hi_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    t_edge |=> (hi_cnt == '0));

  p_low_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (t_stuck && !t_lvl) |=> (mode_q == M_OFF));

  p_mstuck_noshp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (t_stuck && t_lvl && m_stuck) |=> (mode_q == M_NOSHP));

  p_ones_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q[2]) |-> $past(hi_over));

  p_ones_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q |=> !ones_q);

endmodule

// File: tb/txclk_activity_mode_tb_top.sv
module txclk_activity_mode_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tclk_in = 1'b0, mclk_in = 1'b0, pos_in = 1'b0, neg_in = 1'b0;
  logic [3:0] mode_oh;
  logic drv_en, shaper_off, pos_out, neg_out, ones_out;

  int total = 0, bad = 0;
  int tm = 1, mm = 1;
  int tcnt = 0, mcnt = 0;
  logic [1:0] rail = 2'b00;
  logic [5:0] exp_q[$];
  string tag_q[$];
  event smp;

  always #2.5 clk = ~clk;

  txclk_activity_mode dut_i (
    .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .mclk_in(mclk_in),
    .pos_in(pos_in), .neg_in(neg_in), .mode_oh(mode_oh), .drv_en(drv_en),
    .shaper_off(shaper_off), .pos_out(pos_out), .neg_out(neg_out),
    .ones_out(ones_out));

  initial forever begin
    @(posedge clk); #1;
    tcnt++; mcnt++;
    case (tm)
      0: if (tcnt % 8 == 0) begin
           tclk_in = ~tclk_in;
           if (tclk_in) begin
             rail = rail + 2'd1;
             pos_in = rail[0];
             neg_in = rail[1] ^ rail[0];
           end
         end
      1: tclk_in = 1'b0;
      default: tclk_in = 1'b1;
    endcase
    case (mm)
      0: if (mcnt % 6 == 0) mclk_in = ~mclk_in;
      1: mclk_in = 1'b0;
      default: mclk_in = 1'b1;
    endcase
  end

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  initial forever begin
    @smp; #1;
    begin
      logic [5:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {mode_oh, drv_en, shaper_off}, e);
    end
  end

  task automatic expect_mode(input string req, input logic [3:0] m);
    exp_q.push_back({m, (m != 4'b0010), (m == 4'b1000)});
    tag_q.push_back(req);
    -> smp;
    #2;
  endtask

  task automatic count_ones(input string req, input int expv);
    int n = 0;
    for (int i = 0; i < 120; i++) begin
      @(posedge clk); #1;
      if (ones_out) n++;
    end
    check(req, n, expv);
  endtask

  task automatic settle(input int t, input int m, input int cyc);
    tm = t; mm = m;
    repeat (cyc) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    expect_mode("R1 reset mode", 4'b0010);
    check("R1 ones at reset", ones_out, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk); #1;
    expect_mode("R1 after reset tclk low", 4'b0010);

    settle(0, 1, 20); #1;
    expect_mode("R8 edge returns normal", 4'b0001);

    for (int m = 0; m < 3; m++) begin
      settle(0, m, 400); #1;
      expect_mode("R2 tclk toggling", 4'b0001);
      count_ones("R7 no ones in normal", 0);
    end

    for (int k = 0; k < 4; k++) begin
      @(negedge tclk_in);
      begin
        logic p, n;
        p = pos_in; n = neg_in;
        repeat (6) @(posedge clk); #1;
        check("R3 pos capture", pos_out, p);
        check("R3 neg capture", neg_out, n);
      end
    end

    for (int m = 0; m < 3; m++) begin
      settle(1, m, 400); #1;
      expect_mode("R4 tclk low", 4'b0010);
      count_ones("R7 no ones when off", 0);
    end

    settle(0, 0, 100);
    settle(2, 0, 120); #1;
    expect_mode("R5 below limit holds normal", 4'b0001);
    settle(2, 0, 300); #1;
    expect_mode("R5 all ones", 4'b0100);
    count_ones("R7 ones per mclk period", 10);

    settle(2, 1, 400); #1;
    expect_mode("R6 mclk low", 4'b1000);
    count_ones("R7 no ones shaper off", 0);
    settle(2, 2, 400); #1;
    expect_mode("R6 mclk high", 4'b1000);

    settle(0, 2, 40); #1;
    expect_mode("R10 edge within window", 4'b0001);
    settle(1, 2, 40); #1;
    expect_mode("R10 not yet stuck", 4'b0001);
    settle(1, 2, 60); #1;
    expect_mode("R10 stuck after window", 4'b0010);

    repeat (5) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule